// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Watchdog Mode

This block is a programmable down-counting timer that software drives through a small 32-bit register port. A combined count register holds a 16-bit clock divider and a 16-bit period length. The divider is one-based, so a divider field of zero divides by 65536. Once started, the timer raises an expiry flag after (period x divide) clock cycles. In one-shot operation it then stops. In continuous operation it reloads and fires again every period.

The same timer can be turned into a watchdog. While watchdog mode is active, software must restart the countdown before it runs out. It does this by writing the byte 0xA5 alone into the top byte lane of the mode register. If the countdown expires without that write, the block pulses a reset request and records the event in status. Watchdog mode locks the timer: only a write that clears both the run bit and the watchdog bit can stop it.

Register select (`reg_sel`): 0 is the mode register, 1 is the count register, 2 is the status register. Writes honour the byte-lane enables.

Top module: `prescaled_wdog_timer`

## Requirements
- R1: The count register holds the divider in bits 31:16 and the period in bits 15:0. After a start, the expiry status flag is set exactly P x D clock edges after the starting write edge. D is the divider value and P is the period, with a period of 0 acting as 1.
- R2: A divider field of 0 divides the clock by 65536.
- R3: With mode bit 12 (run) set and mode bit 10 (repeat) clear, the timer expires once and then clears its run bit. No further expiry occurs.
- R4: With mode bit 10 set, the timer reloads at expiry and expires again every P x D cycles.
- R5: Status bit 0 is the timer expiry flag and status bit 1 is the watchdog expiry flag. Writing ones to status bits 3:0 clears them. A flag set in the same cycle as a clear stays set.
- R6: The `irq` output is high exactly when mode bit 8 is set and any of status bits 3:0 is set.
- R7: Writing mode bit 15 starts watchdog mode. This forces the run bit to 1 and clears the repeat and interrupt-enable bits, so the mode register reads 0x9000. At expiry the block drives `wdt_reset` high for one cycle, sets status bit 1 and restarts the countdown.
- R8: In watchdog mode, a mode write with only byte lane 3 enabled and data bits 31:24 equal to 0xA5 restarts the countdown. Any other value in that lane has no effect.
- R9: While watchdog mode is active, count-register writes are ignored. Mode writes that do not clear both bit 12 and bit 15 are ignored too.
- R10: A mode write that clears bits 12 and 15 together stops the watchdog. No further `wdt_reset` pulse or expiry follows.
- R11: A count-register write, or a mode write that sets the run bit, reloads both the divider and the period counter. Expiry is then measured from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| reg_sel | input | 2 | Register select: 0 mode, 1 count, 2 status |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request |
| wdt_reset | output | 1 | One-cycle watchdog reset request |

## Verification
The first stimulus is random divider and period pairs, in both one-shot and repeat operation. These show whether the expiry distance is the product of the two fields. They also show whether a repeat timer keeps the same spacing after its flag is cleared. Directed cases cover period 0 against period 1 and the divider-zero wrap to 65536. A mid-count reload shows whether a count write restarts the measurement. The watchdog runs check:
- a correct keepalive against a wrong byte value, which tells a restart apart from an ignored write;
- lockout writes, which must change neither the timing nor the readback;
- the dual-clear stop, after which the block must stay silent.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    localparam int REG_W  = 32;
    localparam int LANES  = REG_W / 8;
    localparam int FLAG_W = 4;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_STAT  = 2'd2
    } reg_sel_e;

    // mode register bit positions
    localparam int MB_WDOG = 15;
    localparam int MB_RUN  = 12;
    localparam int MB_REP  = 10;
    localparam int MB_IRQ  = 8;

    // status flag positions
    localparam int FB_TMR  = 0;
    localparam int FB_WDOG = 1;

    localparam logic [7:0] KICK_BYTE = 8'hA5;

    typedef struct packed {
        logic wdog;
        logic run;
        logic rep;
        logic irq_en;
    } mode_t;

    function automatic logic [REG_W-1:0] mode_to_word(mode_t m);
        logic [REG_W-1:0] w;
        w          = '0;
        w[MB_WDOG] = m.wdog;
        w[MB_RUN]  = m.run;
        w[MB_REP]  = m.rep;
        w[MB_IRQ]  = m.irq_en;
        return w;
    endfunction

    function automatic mode_t word_to_mode(logic [REG_W-1:0] w);
        mode_t m;
        m.wdog   = w[MB_WDOG];
        m.run    = w[MB_RUN];
        m.rep    = w[MB_REP];
        m.irq_en = w[MB_IRQ];
        return m;
    endfunction

    function automatic logic [REG_W-1:0] lane_mask(logic [LANES-1:0] be);
        logic [REG_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/pwt_counter.sv
module pwt_counter #(
    parameter int PS_W  = 16,
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [PS_W-1:0]  ld_ps,
    input  logic [PER_W-1:0] ld_per,
    output logic             expire
);

    logic [PS_W-1:0]  ps_rl, ps_cnt;
    logic [PER_W-1:0] per_rl, per_cnt;
    logic             tick;

    // one-based divider: N-1 wraps 0 to all ones, giving divide by 2^PS_W
    logic [PS_W-1:0] ps_start;
    assign ps_start = ld_ps - PS_W'(1);

    assign tick   = run && (ps_cnt == '0);
    assign expire = tick && (per_cnt <= PER_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_rl   <= '0;
            ps_cnt  <= '0;
            per_rl  <= '0;
            per_cnt <= '0;
        end else if (load) begin
            ps_rl   <= ps_start;
            ps_cnt  <= ps_start;
            per_rl  <= ld_per;
            per_cnt <= ld_per;
        end else if (run) begin
            if (tick) begin
                ps_cnt <= ps_rl;
                if (per_cnt <= PER_W'(1)) per_cnt <= per_rl;
                else                      per_cnt <= per_cnt - PER_W'(1);
            end else begin
                ps_cnt <= ps_cnt - PS_W'(1);
            end
        end
    end

    // the divider never exceeds its reload value while running
    AST_PS_BOUND: assert property (@(posedge clk) disable iff (rst)
        run && !load && !$past(load) && !$past(rst) |-> ps_cnt <= ps_rl) else $error("prescaler out of range"); // R1

endmodule

// File: rtl/pwt_regs.sv
module pwt_regs
    import pwt_pkg::*;
#(
    parameter int PS_W  = 16,
    parameter int PER_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [1:0]        reg_sel,
    input  logic [LANES-1:0]  bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              expire,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              run,
    output logic              load,
    output logic [PS_W-1:0]   ld_ps,
    output logic [PER_W-1:0]  ld_per,
    output logic              irq,
    output logic              wdt_reset
);

    localparam int CNT_W = PS_W + PER_W;

    mode_t              mode_q, mode_d;
    logic [CNT_W-1:0]   count_q, count_d;
    logic [FLAG_W-1:0]  stat_q, stat_d;
    logic               wdt_q;

    logic mode_wr, kick, cnt_wr, stat_wr, stop_req;
    logic [REG_W-1:0] bmask, cnt_word;

    assign bmask    = lane_mask(bus_be);
    assign cnt_word = REG_W'(count_q);

    assign mode_wr  = bus_we && (reg_sel == SEL_MODE) && bus_be[1];
    assign kick     = bus_we && (reg_sel == SEL_MODE) && (bus_be == 4'b1000)
                      && (bus_wdata[31:24] == KICK_BYTE) && mode_q.wdog;
    assign cnt_wr   = bus_we && (reg_sel == SEL_COUNT) && (|bus_be) && !mode_q.wdog;
    assign stat_wr  = bus_we && (reg_sel == SEL_STAT) && bus_be[0];
    assign stop_req = !bus_wdata[MB_WDOG] && !bus_wdata[MB_RUN];

    always_comb begin
        count_d = count_q;
        if (cnt_wr) count_d = CNT_W'((cnt_word & ~bmask) | (bus_wdata & bmask));
    end

    always_comb begin
        mode_d = mode_q;
        if (expire && !mode_q.rep && !mode_q.wdog) mode_d.run = 1'b0;
        if (mode_wr) begin
            if (!mode_q.wdog) begin
                mode_d = word_to_mode(bus_wdata);
                if (mode_d.wdog) begin
                    mode_d.run    = 1'b1;
                    mode_d.rep    = 1'b0;
                    mode_d.irq_en = 1'b0;
                end
            end else if (stop_req) begin
                mode_d = word_to_mode(bus_wdata);
            end
        end
    end

    always_comb begin
        stat_d = stat_q;
        if (stat_wr) stat_d = stat_q & ~bus_wdata[FLAG_W-1:0];
        if (expire) begin
            if (mode_q.wdog) stat_d[FB_WDOG] = 1'b1;
            else             stat_d[FB_TMR]  = 1'b1;
        end
    end

    assign load = cnt_wr || kick
                  || (mode_d.run && !mode_q.run)
                  || (mode_d.wdog && !mode_q.wdog);
    assign ld_ps  = count_d[CNT_W-1:PER_W];
    assign ld_per = count_d[PER_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            count_q <= '0;
            stat_q  <= '0;
            wdt_q   <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            count_q <= count_d;
            stat_q  <= stat_d;
            wdt_q   <= expire && mode_q.wdog;
        end
    end

    assign run       = mode_q.run;
    assign irq       = mode_q.irq_en && (|stat_q);
    assign wdt_reset = wdt_q;

    always_comb begin
        case (reg_sel)
            SEL_MODE:  bus_rdata = mode_to_word(mode_q);
            SEL_COUNT: bus_rdata = cnt_word;
            SEL_STAT:  bus_rdata = REG_W'(stat_q);
            default:   bus_rdata = '0;
        endcase
    end

    AST_TMR_FLAG: assert property (@(posedge clk) disable iff (rst)
        expire && !mode_q.wdog |=> stat_q[FB_TMR]) else $error("timer flag missing"); // R5

    AST_WD_PULSE: assert property (@(posedge clk) disable iff (rst)
        expire && mode_q.wdog |=> wdt_reset && stat_q[FB_WDOG]) else $error("watchdog pulse missing"); // R7

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        expire && !mode_q.rep && !mode_q.wdog && !mode_wr |=> !mode_q.run) else $error("one-shot kept running"); // R3

    AST_WD_HOLD: assert property (@(posedge clk) disable iff (rst)
        mode_q.wdog && !(mode_wr && stop_req) |=> mode_q.wdog && mode_q.run) else $error("watchdog released"); // R9

    AST_CNT_LOCK: assert property (@(posedge clk) disable iff (rst)
        mode_q.wdog |=> $stable(count_q)) else $error("count changed in watchdog"); // R9

endmodule

// File: rtl/prescaled_wdog_timer.sv
module prescaled_wdog_timer #(
    parameter int PS_W  = 16,
    parameter int PER_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [1:0]  reg_sel,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        wdt_reset
);

    logic             run, load, expire;
    logic [PS_W-1:0]  ld_ps;
    logic [PER_W-1:0] ld_per;

    pwt_regs #(.PS_W(PS_W), .PER_W(PER_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .reg_sel   (reg_sel),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .expire    (expire),
        .bus_rdata (bus_rdata),
        .run       (run),
        .load      (load),
        .ld_ps     (ld_ps),
        .ld_per    (ld_per),
        .irq       (irq),
        .wdt_reset (wdt_reset)
    );

    pwt_counter #(.PS_W(PS_W), .PER_W(PER_W)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .load   (load),
        .ld_ps  (ld_ps),
        .ld_per (ld_per),
        .expire (expire)
    );

endmodule

// File: tb/prescaled_wdog_timer_bench.sv
module prescaled_wdog_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [3:0]  bus_be = 4'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wdt_reset;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic wdt_seen = 1'b0;

    localparam logic [31:0] M_RUN = 32'h1000, M_REP = 32'h0400,
                            M_IRQ = 32'h0100, M_WD  = 32'h8000;

    prescaled_wdog_timer u_prescaled_wdog_timer (
        .clk(clk), .rst(rst), .bus_we(bus_we), .reg_sel(reg_sel),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wdt_reset(wdt_reset)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wdt_reset) wdt_seen <= 1'b1;
    end

    function automatic int exp_cycles(int dv, int per);
        int d = (dv == 0) ? 65536 : dv;
        int p = (per == 0) ? 1 : per;
        return d * p;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; reg_sel = a; bus_be = b; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_be = 4'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_sel = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_flag(input int bitn, input int limit);
        int n = 0;
        reg_sel = 2'd2;
        while (n < limit) begin
            @(posedge clk); #1;
            n++;
            if (bus_rdata[bitn]) break;
        end
    endtask

    task automatic start(input int dv, input int per, input logic [31:0] mbits, output int t0);
        wr(2'd0, 4'b0011, 32'h0);
        wr(2'd2, 4'b0001, 32'hF);
        wr(2'd1, 4'b1111, {dv[15:0], per[15:0]});
        wr(2'd0, 4'b0011, mbits | M_RUN);
        t0 = cyc;
    endtask

    initial begin
        logic [31:0] v;
        int t0, t1, e, dv, per, d1;
        void'($urandom(32'd2024));

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        rd(2'd0, v); chk("R7 reset mode", v, 0);
        rd(2'd1, v); chk("R1 reset count", v, 0);
        rd(2'd2, v); chk("R5 reset status", v, 0);
        chk("R6 reset irq", {31'd0, irq}, 0);
        chk("R7 reset wdt", {31'd0, wdt_reset}, 0);

        // R1 directed: period 0 and 1 both take one divider span
        start(3, 0, 0, t0); wait_flag(0, 100);
        chk("R1 period0", cyc - t0, exp_cycles(3, 0));
        start(3, 1, 0, t0); wait_flag(0, 100);
        chk("R1 period1", cyc - t0, exp_cycles(3, 1));
        rd(2'd1, v); chk("R1 count layout", v, 32'h0003_0001);

        // random one-shot / repeat trials
        for (int k = 0; k < 8; k++) begin
            dv  = 1 + ($urandom % 4);
            per = 2 + ($urandom % 6);
            e   = exp_cycles(dv, per);
            if ($urandom % 2) begin
                start(dv, per, M_REP, t0); wait_flag(0, 200);
                chk("R4 first expiry", cyc - t0, e);
                wr(2'd2, 4'b0001, 32'h1);
                wait_flag(0, 200);
                chk("R4 second expiry", cyc - t0, 2 * e);
            end else begin
                start(dv, per, 0, t0); wait_flag(0, 200);
                chk("R1 one-shot expiry", cyc - t0, e);
                rd(2'd0, v); chk("R3 run cleared", v & M_RUN, 0);
                wr(2'd2, 4'b0001, 32'h1);
                repeat (3 * e + 5) @(posedge clk);
                #1; rd(2'd2, v); chk("R3 no second expiry", v, 0);
            end
        end

        // R2 divider zero
        start(0, 1, 0, t0); wait_flag(0, 70000);
        chk("R2 divide by 65536", cyc - t0, 65536);

        // R11 reload on count write mid-run
        start(1, 10, 0, t0);
        while (cyc < t0 + 4) @(posedge clk);
        wr(2'd1, 4'b1111, 32'h0001_000A); t1 = cyc;
        wait_flag(0, 100);
        chk("R11 count write reload", cyc - t1, 10);

        // R6 interrupt gating
        start(1, 2, M_IRQ, t0); wait_flag(0, 50);
        #1; chk("R6 irq high", {31'd0, irq}, 1);
        wr(2'd0, 4'b0011, 32'h0);
        #1; chk("R6 irq masked", {31'd0, irq}, 0);
        rd(2'd2, v); chk("R5 flag held while masked", v, 1);
        wr(2'd0, 4'b0011, M_IRQ);
        wr(2'd2, 4'b0001, 32'h1);
        #1; chk("R5 w1c clears", {31'd0, irq}, 0);

        // R7 watchdog entry and expiry
        wr(2'd2, 4'b0001, 32'hF);
        wr(2'd1, 4'b1111, 32'h0001_0014);
        wr(2'd0, 4'b0011, M_WD | M_REP | M_IRQ); t0 = cyc;
        rd(2'd0, v); chk("R7 mode forced", v, 32'h9000);
        wait_flag(1, 100);
        chk("R7 wd expiry time", cyc - t0, 20);
        chk("R7 wdt_reset high", {31'd0, wdt_reset}, 1);
        e = cyc;
        @(posedge clk); #1;
        chk("R7 wdt_reset one cycle", {31'd0, wdt_reset}, 0);

        // R8 good keepalive
        wr(2'd2, 4'b0001, 32'h2);
        while (cyc < e + 10) @(posedge clk);
        wr(2'd0, 4'b1000, 32'hA500_0000); t1 = cyc;
        wait_flag(1, 100);
        chk("R8 keepalive restarts", cyc - t1, 20);
        e = cyc;

        // R8 wrong byte ignored
        wr(2'd2, 4'b0001, 32'h2);
        while (cyc < e + 8) @(posedge clk);
        wr(2'd0, 4'b1000, 32'h5A00_0000);
        wait_flag(1, 100);
        chk("R8 wrong byte ignored", cyc - e, 20);
        e = cyc;

        // R9 lockout
        wr(2'd2, 4'b0001, 32'h2);
        while (cyc < e + 5) @(posedge clk);
        wr(2'd1, 4'b1111, 32'h0001_0003);
        wr(2'd0, 4'b0011, M_RUN);
        rd(2'd1, v); chk("R9 count locked", v, 32'h0001_0014);
        rd(2'd0, v); chk("R9 mode locked", v, 32'h9000);
        wait_flag(1, 100);
        d1 = cyc - e;
        chk("R9 timing unchanged", d1, 20);

        // R10 stop
        wr(2'd0, 4'b0011, 32'h0);
        wr(2'd2, 4'b0001, 32'hF);
        rd(2'd0, v); chk("R10 mode cleared", v, 0);
        @(negedge clk) wdt_seen = 1'b0;
        repeat (60) @(posedge clk);
        #1; chk("R10 no reset pulse", {31'd0, wdt_seen}, 0);
        rd(2'd2, v); chk("R10 no expiry", v, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL timeout all-requirements act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule